// File: doc/BRIEF.md
# Interrupt Pending-Vector Aggregator

This block gathers interrupt requests from a cascaded legacy interrupt controller and from other link-side sources into a set of banks. Each bank holds a 32-bit pending vector and a 32-bit enable mask. A pending bit is captured on a rising edge of its source line. For every bank, one summary line goes to a downstream router, and it is high while any pending bit in that bank is also enabled.

Software reaches the registers through a plain register bus. The vectors sit at byte offset 0x80 and the enable masks at byte offset 0xA0, each bank 4 bytes after the previous one. A read of a vector returns the raw pending bits. Software acknowledges them by writing the value it read back to the same vector, which clears those bits (write-one-to-clear). The register bus is a control interface with no stream flow. A read is accepted in every cycle and its data comes back exactly one cycle later with a valid strobe, so there is no back-pressure.

Top module: `irq_vec_aggr`

## Requirements
- R1: Reset clears every pending bit, every enable bit, all summary outputs and the read-valid strobe.
- R2: A rising edge on source line b*32+k sets pending bit k of bank b, whether or not that bit is enabled. The legacy controller lines are sources 0..31, which land on bank 0.
- R3: A source held high sets its pending bit only once. After the bit is cleared, it stays clear until the line falls and rises again.
- R4: A write to byte offset 0x80+4*b clears the pending bits of bank b that are 1 in the write data. Bits written as 0 keep their value.
- R5: When a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to byte offset 0xA0+4*b replaces the enable mask of bank b. A read of that offset returns the mask.
- R7: Summary output b is 1 exactly when the AND of pending vector b and enable mask b is nonzero.
- R8: A read of a vector offset returns the pending bits unmasked by the enables.
- R9: A read of an offset outside both register ranges, or of an offset not a multiple of 4, returns zero. A write there changes no register.
- R10: Read data and the valid strobe appear one cycle after the read request. The data reflects the state before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 256 | Source lines, bank b bit k at index b*32+k |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 8 | Byte offset within the configuration window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| bank_irq | output | 8 | Per-bank summary interrupt toward the router |

## Verification
The first input pattern holds sources high for many cycles. This separates edge capture from level capture, because after an acknowledge a level-sensitive design would set the bit again at once. The second pattern lands source edges in the same cycle as acknowledge writes that cover the same bit, which tests the set-over-clear priority. Random enable masks set against random pending patterns show whether summary lines and vector reads are masked correctly. The last pattern covers misaligned, out-of-range and same-cycle read/write accesses, to confirm that decoding ignores them and that reads return the state from before the write.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_EN   = 2'd2
  } reg_kind_e;

  function automatic logic word_hit(input logic [7:0] addr, input int base, input int idx);
    return addr == 8'(base + 4 * idx);
  endfunction
endpackage

// File: rtl/irq_aggr_edge.sv
module irq_aggr_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line,
  output logic [W-1:0] rise
);
  logic [W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line;
  end

  assign rise = line & ~line_q;
endmodule

// File: rtl/irq_aggr_bank.sv
module irq_aggr_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         ack_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic         summary
);
  logic [W-1:0] rise;
  logic [W-1:0] ack_bits;
  logic [W-1:0] pend_nx;

  irq_aggr_edge #(.W(W)) edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .line (src),
    .rise (rise)
  );

  always_comb begin
    ack_bits = ack_we ? wdata : '0;
    // a fresh edge overrides a simultaneous acknowledge
    pend_nx  = (pend & ~ack_bits) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
    end else begin
      pend <= pend_nx;
      if (mask_we) mask <= wdata;
    end
  end

  assign summary = |(pend & mask);
endmodule

// File: rtl/irq_aggr_regif.sv
module irq_aggr_regif
  import irq_aggr_pkg::*;
#(
  parameter int NB       = 8,
  parameter int W        = 32,
  parameter int VEC_BASE = 'h80,
  parameter int EN_BASE  = 'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [NB*W-1:0] pend_flat,
  input  logic [NB*W-1:0] mask_flat,
  output logic [NB-1:0]   ack_we,
  output logic [NB-1:0]   mask_we,
  output logic [W-1:0]    reg_rdata,
  output logic            reg_rvalid
);
  logic [NB-1:0] vec_sel;
  logic [NB-1:0] en_sel;
  logic [W-1:0]  rd_mux;
  reg_kind_e     kind;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign vec_sel[b] = word_hit(reg_addr, VEC_BASE, b);
    assign en_sel[b]  = word_hit(reg_addr, EN_BASE, b);
    assign ack_we[b]  = reg_wr & vec_sel[b];
    assign mask_we[b] = reg_wr & en_sel[b];
  end

  always_comb begin
    if (|vec_sel)     kind = SEL_VEC;
    else if (|en_sel) kind = SEL_EN;
    else              kind = SEL_NONE;
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++) begin
      if (kind == SEL_VEC && vec_sel[b]) rd_mux = rd_mux | pend_flat[b*W +: W];
      if (kind == SEL_EN  && en_sel[b])  rd_mux = rd_mux | mask_flat[b*W +: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_vec_aggr.sv
module irq_vec_aggr #(
  parameter int NB       = 8,
  parameter int W        = 32,
  parameter int VEC_BASE = 'h80,
  parameter int EN_BASE  = 'hA0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*W-1:0] irq_src,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  output logic            reg_rvalid,
  output logic [NB-1:0]   bank_irq
);
  localparam int TOTAL = NB * W;

  logic [TOTAL-1:0] pend_flat;
  logic [TOTAL-1:0] mask_flat;
  logic [NB-1:0]    ack_we;
  logic [NB-1:0]    mask_we;

  irq_aggr_regif #(
    .NB(NB), .W(W), .VEC_BASE(VEC_BASE), .EN_BASE(EN_BASE)
  ) regif_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .pend_flat (pend_flat),
    .mask_flat (mask_flat),
    .ack_we    (ack_we),
    .mask_we   (mask_we),
    .reg_rdata (reg_rdata),
    .reg_rvalid(reg_rvalid)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_aggr_bank #(.W(W)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (irq_src[b*W +: W]),
      .ack_we (ack_we[b]),
      .mask_we(mask_we[b]),
      .wdata  (reg_wdata),
      .pend   (pend_flat[b*W +: W]),
      .mask   (mask_flat[b*W +: W]),
      .summary(bank_irq[b])
    );
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int NB       = 8,
  parameter int W        = 32,
  parameter int VEC_BASE = 'h80,
  parameter int EN_BASE  = 'hA0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NB*W-1:0] irq_src,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [7:0]      reg_addr,
  input logic [W-1:0]    reg_wdata,
  input logic [W-1:0]    reg_rdata,
  input logic            reg_rvalid,
  input logic [NB-1:0]   bank_irq,
  input logic [NB*W-1:0] pend_flat,
  input logic [NB*W-1:0] mask_flat
);
  logic [NB*W-1:0] src_q;
  logic [NB*W-1:0] rise_c;
  logic            mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= irq_src;
  end
  assign rise_c = irq_src & ~src_q;

  always_comb begin
    mapped = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == 8'(VEC_BASE + 4 * b) || reg_addr == 8'(EN_BASE + 4 * b)) mapped = 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_flat == '0 && mask_flat == '0));

  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_c != '0) |=> ((pend_flat & $past(rise_c)) == $past(rise_c)));

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'(VEC_BASE) && rise_c[W-1:0] == '0)
      |=> ((pend_flat[W-1:0] & $past(reg_wdata)) == '0));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat == '0 || mask_flat == '0) |-> (bank_irq == '0));

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |=> (reg_rdata == '0));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
endmodule

bind irq_vec_aggr irq_aggr_chk #(
  .NB(NB), .W(W), .VEC_BASE(VEC_BASE), .EN_BASE(EN_BASE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_src   (irq_src),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_rvalid(reg_rvalid),
  .bank_irq  (bank_irq),
  .pend_flat (pend_flat),
  .mask_flat (mask_flat)
);

// File: tb/irq_vec_aggr_tb_top.sv
`timescale 1ns/1ps
module irq_vec_aggr_tb_top;
  localparam int NB = 8;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*W-1:0] src = '0;
  logic            reg_wr = 1'b0;
  logic            reg_rd = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic [W-1:0]    reg_wdata = '0;
  logic [W-1:0]    reg_rdata;
  logic            reg_rvalid;
  logic [NB-1:0]   bank_irq;

  logic [W-1:0]    m_pend [NB];
  logic [W-1:0]    m_en   [NB];
  logic [NB*W-1:0] m_prev;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_vec_aggr dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .bank_irq(bank_irq)
  );

  function automatic logic [W-1:0] model_read(input logic [7:0] a);
    for (int b = 0; b < NB; b++) begin
      if (a == 8'('h80 + 4 * b)) return m_pend[b];
      if (a == 8'('hA0 + 4 * b)) return m_en[b];
    end
    return '0;
  endfunction

  function automatic logic [NB-1:0] model_summary();
    logic [NB-1:0] s;
    for (int b = 0; b < NB; b++) s[b] = |(m_pend[b] & m_en[b]);
    return s;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_pend[b] = '0; m_en[b] = '0; end
    m_prev = '0;
  endtask

  // one clock: model follows the inputs driven before the edge
  task automatic tick(input string tag);
    logic          rv_exp;
    logic [W-1:0]  rd_exp;
    @(posedge clk);
    rv_exp = reg_rd;
    rd_exp = model_read(reg_addr);
    for (int b = 0; b < NB; b++) begin
      logic [W-1:0] rise;
      logic [W-1:0] clr;
      rise = src[b*W +: W] & ~m_prev[b*W +: W];
      clr  = (reg_wr && reg_addr == 8'('h80 + 4 * b)) ? reg_wdata : '0;
      m_pend[b] = (m_pend[b] & ~clr) | rise;
      if (reg_wr && reg_addr == 8'('hA0 + 4 * b)) m_en[b] = reg_wdata;
    end
    m_prev = src;
    @(negedge clk);
    check(reg_rvalid == rv_exp, {tag, " R10 rvalid"}, W'(reg_rvalid), W'(rv_exp));
    if (rv_exp) check(reg_rdata == rd_exp, {tag, " rdata"}, reg_rdata, rd_exp);
    check(bank_irq == model_summary(), {tag, " R7 summary"}, W'(bank_irq), W'(model_summary()));
    reg_wr = 1'b0;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d, input string tag);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    tick(tag);
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < NB; b++) begin
      rd(8'('h80 + 4 * b), tag);
      rd(8'('hA0 + 4 * b), tag);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    check(reg_rvalid == 1'b0 && bank_irq == '0, "R1 outputs in reset", W'(bank_irq), '0);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 reset values");

    // R2: edges captured while disabled, raw read (R8), no summary
    src[5] = 1'b1; src[3*W + 17] = 1'b1;
    tick("R2 edge");
    rd(8'h80, "R2 R8 bank0 raw");
    rd(8'h8C, "R2 R8 bank3 raw");
    check(bank_irq == '0, "R8 masked summary low", W'(bank_irq), '0);

    // R6 enable write/readback, R7 summary rise
    wr(8'hAC, 32'h0002_0000, "R6 en bank3");
    rd(8'hAC, "R6 readback");
    check(bank_irq == 8'h08, "R7 bank3 summary", W'(bank_irq), 32'h08);

    // R4 partial ack, R3 held level does not re-set
    wr(8'h80, 32'h0000_0001, "R4 zero bits kept");
    rd(8'h80, "R4 bit5 still set");
    wr(8'h80, 32'h0000_0020, "R4 ack bit5");
    repeat (3) tick("R3 held high");
    rd(8'h80, "R3 no re-set");
    src[5] = 1'b0; tick("R3 fall");
    src[5] = 1'b1; tick("R3 new edge");
    rd(8'h80, "R3 re-set on new edge");

    // R5 edge and ack on the same bit in one cycle
    src[7] = 1'b0; tick("R5 prep");
    src[7] = 1'b1; reg_wr = 1'b1; reg_addr = 8'h80; reg_wdata = 32'h0000_00A0;
    tick("R5 set wins");
    rd(8'h80, "R5 readback");

    // R9 unmapped / misaligned accesses
    rd(8'h00, "R9 low");
    rd(8'h81, "R9 misaligned");
    rd(8'hA2, "R9 misaligned en");
    rd(8'hC0, "R9 above");
    rd(8'hFC, "R9 top");
    wr(8'h82, 32'hFFFF_FFFF, "R9 wr misaligned");
    wr(8'hC4, 32'hFFFF_FFFF, "R9 wr above");
    read_all("R9 state unchanged");

    // R10 read and write same cycle returns old
    reg_rd = 1'b1; reg_wr = 1'b1; reg_addr = 8'hA4; reg_wdata = 32'h1234_5678;
    tick("R10 same-cycle old data");
    rd(8'hA4, "R10 new data visible");

    // R7 all enables on bank 0
    wr(8'hA0, 32'hFFFF_FFFF, "R7 enable all bank0");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      int bk;
      for (int b = 0; b < NB; b++)
        src[b*W +: W] = src[b*W +: W] ^ ($urandom() & $urandom() & $urandom() & $urandom());
      op = $urandom_range(0, 5);
      bk = $urandom_range(0, NB - 1);
      case (op)
        0: ;
        1: begin reg_wr = 1'b1; reg_addr = 8'('h80 + 4 * bk); reg_wdata = m_pend[bk]; end
        2: begin reg_wr = 1'b1; reg_addr = 8'('h80 + 4 * bk); reg_wdata = $urandom(); end
        3: begin reg_wr = 1'b1; reg_addr = 8'('hA0 + 4 * bk); reg_wdata = $urandom() & $urandom(); end
        4: begin reg_rd = 1'b1; reg_addr = 8'($urandom_range(0, 255)); end
        default: begin reg_rd = 1'b1; reg_addr = 8'('h80 + 4 * bk + 32 * $urandom_range(0, 1)); end
      endcase
      if ($urandom_range(0, 3) == 0) reg_rd = 1'b1;
      tick("R2 R4 R7 random");
    end

    // R1 reset after activity
    rst_n = 1'b0;
    src = '0;
    repeat (2) @(negedge clk);
    model_reset();
    check(bank_irq == '0 && reg_rvalid == 1'b0, "R1 mid-run reset outputs", W'(bank_irq), '0);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1 mid-run reset values");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule